// File: doc/BRIEF.md
# Fuse Block Access Controller

This block fronts a one-time-programmable fuse store that is organised as 16-byte blocks. Software addresses it through six 32-bit register slots: one control word and four data words that stage a whole block, plus a read-only window onto one halfword of the staged block. Software writes the control word with a block address, an operation mode and a start bit. The controller then stays busy for a fixed number of cycles and carries out one of three operations: a physical read, a physical write, or a logical read. A physical write can only set fuse bits. A logical read translates a logical block number into a physical one through a table of map entries that are themselves stored in fuses.

The fuse store is a register array inside the block that resets to all zeros. The topmost `MAP_BLK` blocks hold the map table. There is one entry byte for each data block. An entry carries a 6-bit logical block number and two check bits. An entry whose check bits do not match is treated as empty. An entry can therefore be retired by setting further bits in it, which is something a fuse is still able to do.

Top module: `fuse_blk_ctrl`

## Requirements
- R1: After reset:
  - The control slot (index 0) reads 0x0000003f: address 0, mode 0, start bit 0 and result field 0x3f.
  - The data slots (indices 1 to 4 hold data words 0 to 3) read 0.
  - The halfword slot (index 5) reads 0.
  - Every fuse block reads back as zero.
- R2: Control word layout: bit 30 is start/busy, bits 25:16 are the address, bits 7:6 are the mode and bits 5:0 are the read-only result field.
  - Writing the control word while idle stores the address and the mode.
  - If bit 30 is 1 in that write, an operation starts, and bit 30 then reads 1 for exactly `LATENCY` cycles before it returns to 0.
- R3: While bit 30 reads 1, writes to the control slot and to the data slots are ignored.
- R4: Mode 1 (physical read) loads block address[9:4] into the data slots, with data word k holding block bits 32k+31:32k (word 0 is least significant). A block index at or above `NUM_BLK` reads as zero.
- R5: Mode 3 (physical write) ORs the four data words into block address[9:4], so no fuse bit ever goes from 1 to 0. A block index at or above `NUM_BLK` changes nothing.
- R6: Map table layout:
  - The map entry for physical block p is byte p mod 16 of block `NUM_BLK-MAP_BLK` + p/16.
  - Entries exist for blocks 0 to `NUM_BLK-MAP_BLK`-1.
  - Bits 5:0 of an entry hold the logical block number.
  - An entry is valid only when bit 6 equals the inverted XOR of bits 3:0 and bit 7 equals the inverted XOR of bits 5:2.
- R7: Mode 0 (logical read) treats address[9:4] as a logical block number. If a valid entry matches, the physical block number goes into the result field and that block is loaded into the data slots. When several entries match, the lowest physical block wins.
- R8: A logical read that finds no valid matching entry sets the result field to 0x3f and all four data words to 0xffffffff.
- R9: The halfword slot reads bits 15:0 of data word address[3:2] shifted right by 8 times address[1:0]. Bits 31:16 of that slot read 0.
- R10: Mode 2 leaves the data slots, the result field and the fuse array unchanged. Its start bit still clears after `LATENCY` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register slot index for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for slot `reg_idx_i` (combinational) |

## Verification
The bench builds the block with `NUM_BLK=17`, `MAP_BLK=1` and `LATENCY=4`:
- A single map block then holds all 16 entries, so one physical write can place or corrupt any entry.
- The short latency lets the bench count busy cycles exactly.
- With 17 blocks the internal index is 5 bits wide, so out-of-range indices such as 20 and 33 reach the range guard. Index 33 would alias to block 1 if that guard were missing.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  typedef enum logic [1:0] {
    MODE_LOG_RD  = 2'd0,
    MODE_PHYS_RD = 2'd1,
    MODE_RSVD    = 2'd2,
    MODE_PHYS_WR = 2'd3
  } fuse_mode_e;

  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_DATA0 = 3'd1;
  localparam logic [2:0] IDX_HALF  = 3'd5;

  localparam int CTRL_START = 30;
  localparam int BLK_BITS   = 128;
  localparam logic [5:0] NOT_FOUND = 6'h3f;

  function automatic logic entry_ok(input logic [7:0] e);
    return (e[6] == ~^e[3:0]) && (e[7] == ~^e[5:2]);
  endfunction
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int NUM_BLK = 48,
  parameter int MAP_BLK = 3,
  localparam int MAP_ENT = NUM_BLK - MAP_BLK,
  localparam int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [5:0]           wr_blk_i,
  input  logic [127:0]         wr_data_i,
  input  logic [5:0]           rd_blk_i,
  output logic [127:0]         rd_data_o,
  output logic [MAP_ENT*8-1:0] map_o
);
  logic [127:0] mem_q [NUM_BLK];
  logic wr_in_range, rd_in_range;

  assign wr_in_range = int'(wr_blk_i) < NUM_BLK;
  assign rd_in_range = int'(rd_blk_i) < NUM_BLK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BLK; b++) mem_q[b] <= '0;
    end else if (wr_en_i && wr_in_range) begin
      mem_q[wr_blk_i[IDX_W-1:0]] <= mem_q[wr_blk_i[IDX_W-1:0]] | wr_data_i;
    end
  end

  assign rd_data_o = rd_in_range ? mem_q[rd_blk_i[IDX_W-1:0]] : '0;

  for (genvar p = 0; p < MAP_ENT; p++) begin : g_map
    assign map_o[p*8 +: 8] = mem_q[MAP_ENT + p/16][(p%16)*8 +: 8];
  end

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_chk
    // R5: fuse bits only ever go from 0 to 1
    a_r5_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_q[b] & $past(mem_q[b])) == $past(mem_q[b]));
  end
endmodule

// File: rtl/fuse_map_lookup.sv
module fuse_map_lookup
  import fuse_pkg::*;
#(
  parameter int MAP_ENT = 45
) (
  input  logic [MAP_ENT*8-1:0] map_i,
  input  logic [5:0]           lblk_i,
  output logic                 hit_o,
  output logic [5:0]           pblk_o
);
  // Scan from the top so the lowest matching physical block is left standing.
  always_comb begin
    hit_o  = 1'b0;
    pblk_o = NOT_FOUND;
    for (int p = MAP_ENT - 1; p >= 0; p--) begin
      if (entry_ok(map_i[p*8 +: 8]) && map_i[p*8 +: 6] == lblk_i) begin
        hit_o  = 1'b1;
        pblk_o = 6'(p);
      end
    end
  end
endmodule

// File: rtl/fuse_blk_ctrl.sv
module fuse_blk_ctrl
  import fuse_pkg::*;
#(
  parameter int NUM_BLK = 48,
  parameter int MAP_BLK = 3,
  parameter int LATENCY = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_idx_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  localparam int MAP_ENT = NUM_BLK - MAP_BLK;
  localparam int CNT_W   = $clog2(LATENCY + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [9:0]       addr_q;
  fuse_mode_e       mode_q;
  logic [5:0]       aout_q;
  logic [127:0]     data_q;

  logic             done;
  logic             hit;
  logic [5:0]       pblk;
  logic [5:0]       rd_blk;
  logic [127:0]     rd_data;
  logic [MAP_ENT*8-1:0] map_bytes;
  logic [31:0]      word_sel, word_shift;
  logic             unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[31], reg_wdata_i[29:26], reg_wdata_i[15:8], reg_wdata_i[5:0]};

  assign done   = busy_q && (cnt_q == CNT_W'(LATENCY - 1));
  assign rd_blk = (mode_q == MODE_LOG_RD) ? pblk : addr_q[9:4];

  fuse_array #(.NUM_BLK(NUM_BLK), .MAP_BLK(MAP_BLK)) i_array (
    .clk_i, .rst_ni,
    .wr_en_i  (done && mode_q == MODE_PHYS_WR),
    .wr_blk_i (addr_q[9:4]),
    .wr_data_i(data_q),
    .rd_blk_i (rd_blk),
    .rd_data_o(rd_data),
    .map_o    (map_bytes)
  );

  fuse_map_lookup #(.MAP_ENT(MAP_ENT)) i_lookup (
    .map_i (map_bytes),
    .lblk_i(addr_q[9:4]),
    .hit_o (hit),
    .pblk_o(pblk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      mode_q <= MODE_LOG_RD;
      aout_q <= NOT_FOUND;
      data_q <= '0;
    end else if (busy_q) begin
      if (!done) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        busy_q <= 1'b0;
        unique case (mode_q)
          MODE_LOG_RD: begin
            aout_q <= hit ? pblk : NOT_FOUND;
            data_q <= hit ? rd_data : '1;
          end
          MODE_PHYS_RD: data_q <= rd_data;
          default: ;
        endcase
      end
    end else if (reg_we_i) begin
      if (reg_idx_i == IDX_CTRL) begin
        addr_q <= reg_wdata_i[25:16];
        mode_q <= fuse_mode_e'(reg_wdata_i[7:6]);
        if (reg_wdata_i[CTRL_START]) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end
      for (int w = 0; w < 4; w++) begin
        if (reg_idx_i == IDX_DATA0 + 3'(w)) data_q[32*w +: 32] <= reg_wdata_i;
      end
    end
  end

  assign word_sel   = data_q[{addr_q[3:2], 5'b0} +: 32];
  assign word_shift = word_sel >> {addr_q[1:0], 3'b0};

  always_comb begin
    unique case (reg_idx_i)
      3'd0:    reg_rdata_o = {1'b0, busy_q, 4'b0, addr_q, 8'b0, mode_q, aout_q};
      3'd1:    reg_rdata_o = data_q[31:0];
      3'd2:    reg_rdata_o = data_q[63:32];
      3'd3:    reg_rdata_o = data_q[95:64];
      3'd4:    reg_rdata_o = data_q[127:96];
      3'd5:    reg_rdata_o = {16'b0, word_shift[15:0]};
      default: reg_rdata_o = '0;
    endcase
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < CNT_W'(LATENCY));
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && reg_we_i && reg_idx_i == IDX_CTRL && reg_wdata_i[CTRL_START])
      |=> (busy_q && cnt_q == '0));
  a_r2_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy_q);
  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done) |=> ($stable(data_q) && $stable(addr_q) && $stable(mode_q)));
  a_r8_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && mode_q == MODE_LOG_RD && !hit) |=> (aout_q == NOT_FOUND && data_q == '1));
  a_r10_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && mode_q == MODE_RSVD) |=> ($stable(data_q) && $stable(aout_q)));
endmodule

// File: tb/test_fuse_blk_ctrl.sv
module test_fuse_blk_ctrl;
  localparam int NB  = 17;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  logic [127:0] exp_mem [NB];

  always #4 clk = ~clk;

  fuse_blk_ctrl #(.NUM_BLK(NB), .MAP_BLK(1), .LATENCY(LAT)) i_fuse_blk_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  // {block, pattern}: word k is written as pattern ^ {8{k}}
  localparam logic [37:0] VEC [6] = '{
    {6'd0,  32'hA5A5_0F0F}, {6'd0,  32'h5A5A_F0F0}, {6'd2, 32'h0000_0001},
    {6'd2,  32'h8000_0000}, {6'd15, 32'h1234_5678}, {6'd5, 32'hFFFF_0000}
  };

  function automatic logic [31:0] cw(bit start, logic [9:0] a, logic [1:0] m);
    return {1'b0, start, 4'b0, a, 8'b0, m, 6'b0};
  endfunction

  function automatic logic [7:0] mk_entry(logic [5:0] lb);
    return {~^lb[5:2], ~^lb[3:0], lb};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; #1;
    d = reg_rdata;
  endtask

  task automatic rd_data(output logic [127:0] d);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      reg_rd(3'(k + 1), w);
      d[32*k +: 32] = w;
    end
  endtask

  task automatic run_op(logic [1:0] m, logic [9:0] a, output int n);
    logic [31:0] c;
    reg_wr(3'd0, cw(1'b1, a, m));
    n = 0;
    for (int g = 0; g < 1000; g++) begin
      reg_rd(3'd0, c);
      if (!c[30]) break;
      n++;
    end
  endtask

  task automatic phys_wr(int blk, logic [127:0] d);
    int n;
    for (int k = 0; k < 4; k++) reg_wr(3'(k + 1), d[32*k +: 32]);
    run_op(2'd3, {6'(blk), 4'b0}, n);
    if (blk < NB) exp_mem[blk] = exp_mem[blk] | d;
  endtask

  task automatic phys_rd(int blk, output logic [127:0] d);
    int n;
    run_op(2'd1, {6'(blk), 4'b0}, n);
    rd_data(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0]  r;
    logic [127:0] d, pat;
    int n;
    for (int b = 0; b < NB; b++) exp_mem[b] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    // R1 reset state
    reg_rd(3'd0, r); chk("R1 ctrl", 128'(r), 128'h3f);
    rd_data(d);      chk("R1 data", d, '0);
    reg_rd(3'd5, r); chk("R1 half", 128'(r), '0);

    // R2 busy lasts LATENCY cycles; R1 array zero
    run_op(2'd1, {6'd7, 4'b0}, n);
    chk("R2 busy cycles", 128'(n), 128'(LAT));
    rd_data(d); chk("R1 block7 zero", d, '0);

    // R2 write without start stores fields only
    reg_wr(3'd0, cw(1'b0, 10'h2a5, 2'd3));
    reg_rd(3'd0, r); chk("R2 no start", 128'(r), 128'({1'b0, 1'b0, 4'b0, 10'h2a5, 8'b0, 2'd3, 6'h3f}));

    // R4 R5 vector table: OR-write then physical readback
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < 4; k++) pat[32*k +: 32] = VEC[v][31:0] ^ {8{4'(k)}};
      phys_wr(int'(VEC[v][37:32]), pat);
      phys_rd(int'(VEC[v][37:32]), d);
      chk("R5 or-write readback", d, exp_mem[VEC[v][37:32]]);
    end
    phys_rd(0, d); chk("R4 block0 word order", d, exp_mem[0]);

    // R3 writes during busy ignored
    reg_wr(3'd0, cw(1'b1, {6'd2, 4'b0}, 2'd1));
    reg_wr(3'd1, 32'hDEAD_BEEF);
    reg_wr(3'd0, cw(1'b0, {6'd9, 4'b0}, 2'd3));
    repeat (LAT + 2) @(negedge clk);
    reg_rd(3'd1, r); chk("R3 data write ignored", 128'(r), 128'(exp_mem[2][31:0]));
    reg_rd(3'd0, r); chk("R3 ctrl write ignored", 128'(r[25:6]), 128'({6'd2, 4'b0, 8'b0, 2'd1}));

    // R4 out of range reads zero; R5 out of range write ignored
    phys_rd(20, d); chk("R4 out of range read", d, '0);
    phys_wr(33, {4{32'h0F0F_F0F0}});
    phys_rd(1, d); chk("R5 out of range write", d, '0);

    // R8 unmapped logical read
    run_op(2'd0, {6'd9, 4'b0}, n);
    reg_rd(3'd0, r); chk("R8 result", 128'(r[5:0]), 128'h3f);
    rd_data(d); chk("R8 data ones", d, {128{1'b1}});

    // R6 R7 map phys 3 -> logical 9
    phys_wr(3, {32'h3333_0003, 32'h3333_1003, 32'h3333_2003, 32'h3333_3003});
    phys_wr(16, 128'(mk_entry(6'd9)) << 24);
    run_op(2'd0, {6'd9, 4'b0}, n);
    reg_rd(3'd0, r); chk("R7 result hit", 128'(r[5:0]), 128'd3);
    rd_data(d); chk("R7 data hit", d, exp_mem[3]);

    // R7 duplicate: phys 1 also maps logical 9, lowest wins
    phys_wr(1, {4{32'h1111_1111}});
    phys_wr(16, 128'(mk_entry(6'd9)) << 8);
    run_op(2'd0, {6'd9, 4'b0}, n);
    reg_rd(3'd0, r); chk("R7 lowest wins", 128'(r[5:0]), 128'd1);
    rd_data(d); chk("R7 lowest data", d, exp_mem[1]);

    // R6 bad check bits -> miss
    phys_wr(16, 128'({~mk_entry(6'd12)[7:6], 6'd12}) << 40);
    run_op(2'd0, {6'd12, 4'b0}, n);
    reg_rd(3'd0, r); chk("R6 bad parity miss", 128'(r[5:0]), 128'h3f);

    // R9 halfword view
    run_op(2'd1, {6'd3, 4'b0110}, n);
    reg_rd(3'd5, r); chk("R9 half w1 s2", 128'(r), 128'(exp_mem[3][63:48]));
    reg_wr(3'd0, cw(1'b0, {6'd3, 4'b1111}, 2'd1));
    reg_rd(3'd5, r); chk("R9 half w3 s3", 128'(r), 128'({8'b0, exp_mem[3][127:120]}));

    // R10 reserved mode
    reg_wr(3'd0, cw(1'b0, {6'd5, 4'b0}, 2'd0));
    for (int k = 0; k < 4; k++) reg_wr(3'(k + 1), 32'hC0DE_0000 + k);
    run_op(2'd2, {6'd3, 4'b0}, n);
    chk("R10 busy cycles", 128'(n), 128'(LAT));
    rd_data(d); chk("R10 data kept", d, {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000});
    reg_rd(3'd0, r); chk("R10 result kept", 128'(r[5:0]), 128'h3f);
    phys_rd(3, d); chk("R10 array kept", d, exp_mem[3]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule